// File: doc/BRIEF.md
# Pin Event Interrupt Unit

The unit watches the eight input pins of one general-purpose port and turns chosen pin events into one interrupt request. Each pin has its own detection mode, held in a 24-bit sense register: high level, low level, rising edge, falling edge, or any edge. When a pin's condition is seen, a sticky status bit is set. An enable mask decides which status bits may drive the shared interrupt line. Software clears status bits by writing ones to an acknowledge register.

Software reaches the registers through a simple single-cycle write strobe with address and data, and a combinational read port. The status, enable and sense registers also have masked-write aliases. With these, one pin's settings can be changed without a read-modify-write sequence, so two agents can share the port without racing each other. The pin inputs must already be synchronous to the unit's clock.

Top module: `pinirq_port_unit`

## Requirements
- R1: After reset the status, enable and sense registers read as zero, and `irq` is low.
- R2: Reads return status at 0x040, enable at 0x050 and the sense register (bits 23:0) at 0x060. The acknowledge address 0x070, the masked aliases and all unmapped addresses read as zero.
- R3: A plain write to 0x040 or 0x050 replaces that register with wdata[7:0]. A masked write to 0x840 or 0x850 changes only the bits n for which wdata[8+n] is 1, loading wdata[n] into each of them.
- R4: A masked write to 0x860 changes pins n with wdata[24+n]=1. For each such pin it loads sense bits n, 8+n and 16+n from the same wdata bits. A plain write to 0x060 loads wdata[23:0].
- R5: Level mode (sense bit 8+n = 0) sets status n in every cycle in which pin n equals sense bit n (1 = high, 0 = low). An acknowledge therefore does not clear the bit while the level persists.
- R6: Rising mode (bits n and 8+n set, bit 16+n clear) sets status n when pin n goes from 0 to 1 between consecutive cycles. A falling transition does not set it.
- R7: Falling mode (bit 8+n set, bits n and 16+n clear) sets status n on a 1-to-0 transition only.
- R8: Any-edge mode (bits 8+n and 16+n set) sets status n on either transition.
- R9: Writing 0x070 clears status bit n when wdata[n] is 1. Bits written as 0 are left unchanged.
- R10: If a pin detection happens in the same cycle as a write that would clear that status bit, the detection wins and the bit stays set.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1. With the enable register at zero, `irq` stays low.
- R12: A status bit that has been set stays set after the pin condition goes away, until software clears or overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronised pin levels |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Port interrupt request |

## Verification
The assertions assume that `pin_in` only changes synchronously to `clk`. They also assume that at most one register write is presented per cycle, so that one cycle's pin sample against the previous one fully describes an edge. The stimulus changes pins and write fields only on the falling clock edge and holds them for a full cycle. Random pin toggles are mixed with random writes across all seven writable addresses, so that acknowledges often coincide with fresh edges and level conditions.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_STATUS = 12'h040;
  localparam logic [ADDR_W-1:0] A_ENABLE = 12'h050;
  localparam logic [ADDR_W-1:0] A_SENSE  = 12'h060;
  localparam logic [ADDR_W-1:0] A_ACK    = 12'h070;
  localparam logic [ADDR_W-1:0] A_MASKED = 12'h800;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_STAT,
    WR_STAT_M,
    WR_ENAB,
    WR_ENAB_M,
    WR_SENSE,
    WR_SENSE_M,
    WR_ACK
  } wr_kind_e;
endpackage

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
  parameter int unsigned NPIN = 8
) (
  input  logic [NPIN-1:0]   pin,
  input  logic [NPIN-1:0]   pin_prev,
  input  logic [3*NPIN-1:0] sense,
  output logic [NPIN-1:0]   hit
);
  for (genvar n = 0; n < NPIN; n++) begin : g_lane
    logic pol, edge_sel, any_edge, rise, fall;
    assign pol      = sense[n];
    assign edge_sel = sense[NPIN + n];
    assign any_edge = sense[2*NPIN + n];
    assign rise     = pin[n] & ~pin_prev[n];
    assign fall     = ~pin[n] & pin_prev[n];

    always_comb begin
      if (edge_sel) begin
        if (any_edge) hit[n] = rise | fall;
        else          hit[n] = pol ? rise : fall;
      end else begin
        hit[n] = pol ? pin[n] : ~pin[n];
      end
    end
  end
endmodule

// File: rtl/pinirq_wr_path.sv
module pinirq_wr_path
  import pinirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPIN-1:0]   stat_q,
  input  logic [NPIN-1:0]   enab_q,
  input  logic [3*NPIN-1:0] sense_q,
  output logic [NPIN-1:0]   stat_sw,
  output logic [NPIN-1:0]   enab_d,
  output logic              enab_en,
  output logic [3*NPIN-1:0] sense_d,
  output logic              sense_en
);
  localparam int unsigned LANES = 3;

  wr_kind_e kind;
  logic [NPIN-1:0]   lo_val, lo_sel, ty_sel;
  logic [3*NPIN-1:0] ty_val, sense_merged;

  assign lo_val = wdata[NPIN-1:0];
  assign lo_sel = wdata[2*NPIN-1:NPIN];
  assign ty_val = wdata[3*NPIN-1:0];
  assign ty_sel = wdata[4*NPIN-1:3*NPIN];

  always_comb begin
    kind = WR_NONE;
    if (we) begin
      unique case (addr)
        A_STATUS:            kind = WR_STAT;
        A_STATUS | A_MASKED: kind = WR_STAT_M;
        A_ENABLE:            kind = WR_ENAB;
        A_ENABLE | A_MASKED: kind = WR_ENAB_M;
        A_SENSE:             kind = WR_SENSE;
        A_SENSE | A_MASKED:  kind = WR_SENSE_M;
        A_ACK:               kind = WR_ACK;
        default:             kind = WR_NONE;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_merge
    assign sense_merged[l*NPIN +: NPIN] =
      (sense_q[l*NPIN +: NPIN] & ~ty_sel) | (ty_val[l*NPIN +: NPIN] & ty_sel);
  end

  always_comb begin
    stat_sw  = stat_q;
    enab_d   = enab_q;
    enab_en  = 1'b0;
    sense_d  = sense_q;
    sense_en = 1'b0;
    case (kind)
      WR_STAT:    stat_sw = lo_val;
      WR_STAT_M:  stat_sw = (stat_q & ~lo_sel) | (lo_val & lo_sel);
      WR_ACK:     stat_sw = stat_q & ~lo_val;
      WR_ENAB:    begin enab_d = lo_val; enab_en = 1'b1; end
      WR_ENAB_M:  begin enab_d = (enab_q & ~lo_sel) | (lo_val & lo_sel); enab_en = 1'b1; end
      WR_SENSE:   begin sense_d = ty_val; sense_en = 1'b1; end
      WR_SENSE_M: begin sense_d = sense_merged; sense_en = 1'b1; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/pinirq_rd_mux.sv
module pinirq_rd_mux
  import pinirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   stat_q,
  input  logic [NPIN-1:0]   enab_q,
  input  logic [3*NPIN-1:0] sense_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    case (addr)
      A_STATUS: rdata[NPIN-1:0]   = stat_q;
      A_ENABLE: rdata[NPIN-1:0]   = enab_q;
      A_SENSE:  rdata[3*NPIN-1:0] = sense_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinirq_port_unit.sv
module pinirq_port_unit
  import pinirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NPIN-1:0]   stat_q, stat_d, stat_sw, enab_q, enab_d, prev_q, hit;
  logic [3*NPIN-1:0] sense_q, sense_d;
  logic              enab_en, sense_en;

  // reset asserts asynchronously, leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pinirq_wr_path #(.NPIN(NPIN), .DATA_W(DATA_W)) u_wr (
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .stat_q(stat_q), .enab_q(enab_q), .sense_q(sense_q),
    .stat_sw(stat_sw), .enab_d(enab_d), .enab_en(enab_en),
    .sense_d(sense_d), .sense_en(sense_en)
  );

  pinirq_detect #(.NPIN(NPIN)) u_det (
    .pin(pin_in), .pin_prev(prev_q), .sense(sense_q), .hit(hit)
  );

  pinirq_rd_mux #(.NPIN(NPIN), .DATA_W(DATA_W)) u_rd (
    .addr(reg_addr), .stat_q(stat_q), .enab_q(enab_q), .sense_q(sense_q),
    .rdata(reg_rdata)
  );

  // hardware set has priority over any software change of status
  always_comb stat_d = stat_sw | hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q  <= '0;
      enab_q  <= '0;
      sense_q <= '0;
      prev_q  <= '0;
    end else begin
      stat_q <= stat_d;
      prev_q <= pin_in;
      if (enab_en)  enab_q  <= enab_d;
      if (sense_en) sense_q <= sense_d;
    end
  end

  assign irq = |(stat_q & enab_q);
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk
  import pinirq_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   pin_in,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   enab,
  input logic [3*NPIN-1:0] sense
);
  logic [NPIN-1:0] pin_seen;
  logic            started;
  logic            sw_touch, ack_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_seen <= '0;
      started  <= 1'b0;
    end else begin
      pin_seen <= pin_in;
      started  <= 1'b1;
    end
  end

  assign ack_wr   = reg_we && (reg_addr == A_ACK);
  assign sw_touch = reg_we && (reg_addr == A_STATUS ||
                               reg_addr == (A_STATUS | A_MASKED) ||
                               reg_addr == A_ACK);

  // R1
  enab_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (enab == '0 && sense == '0 && stat == '0));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enab == '0) |-> !irq);

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    // R6
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[n] && sense[NPIN+n] && !sense[2*NPIN+n] && !pin_seen[n] && pin_in[n])
      |=> stat[n]);

    // R10
    ack_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && reg_wdata[n] && sense[NPIN+n] && sense[2*NPIN+n] &&
       (pin_in[n] != pin_seen[n])) |=> stat[n]);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && reg_wdata[n] && sense[NPIN+n] && (pin_in[n] == pin_seen[n]))
      |=> !stat[n]);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[n] && !sw_touch) |=> stat[n]);

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense[NPIN+n] && (pin_in[n] == sense[n])) |=> stat[n]);
  end
endmodule

bind pinirq_port_unit pinirq_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .stat(stat_q), .enab(enab_q), .sense(sense_q)
);

// File: tb/pinirq_port_unit_tb.sv
`timescale 1ns/1ps
module pinirq_port_unit_tb_top;
  import pinirq_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pin_in;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  mstat, menab, mprev, cur;
  logic [23:0] msense;

  pinirq_port_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.3;
    v = reg_rdata;
  endtask

  function automatic logic [7:0] hits(input logic [7:0] p, input logic [7:0] pv,
                                      input logic [23:0] s);
    logic [7:0] h;
    for (int n = 0; n < 8; n++) begin
      logic r, f;
      r = p[n] & ~pv[n];
      f = ~p[n] & pv[n];
      if (!s[8+n])       h[n] = s[n] ? p[n] : ~p[n];
      else if (s[16+n])  h[n] = r | f;
      else if (s[n])     h[n] = r;
      else               h[n] = f;
    end
    return h;
  endfunction

  task automatic step(input logic [7:0] pins, input logic we,
                      input logic [11:0] a, input logic [31:0] d);
    logic [7:0]  ns, ne, sel, val;
    logic [23:0] nt;
    logic [31:0] v;
    @(negedge clk);
    pin_in = pins; reg_we = we; reg_addr = a; reg_wdata = d;
    ns = mstat; ne = menab; nt = msense;
    sel = d[15:8]; val = d[7:0];
    if (we) begin
      case (a)
        A_STATUS:            ns = val;
        A_STATUS | A_MASKED: ns = (mstat & ~sel) | (val & sel);
        A_ACK:               ns = mstat & ~val;
        A_ENABLE:            ne = val;
        A_ENABLE | A_MASKED: ne = (menab & ~sel) | (val & sel);
        A_SENSE:             nt = d[23:0];
        A_SENSE | A_MASKED:
          for (int l = 0; l < 3; l++)
            nt[l*8 +: 8] = (msense[l*8 +: 8] & ~d[31:24]) | (d[l*8 +: 8] & d[31:24]);
        default: ;
      endcase
    end
    ns = ns | hits(pins, mprev, msense);
    @(posedge clk);
    #1;
    mstat = ns; menab = ne; msense = nt; mprev = pins;
    reg_we = 1'b0;
    rd(A_STATUS, v);
    check("R12 model status", v, {24'h0, mstat});
    check("R11 model irq", {31'h0, irq}, {31'h0, |(mstat & menab)});
  endtask

  task automatic idle();
    step(cur, 1'b0, 12'h000, 32'h0);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    void'($urandom(32'd4711));
    rst_n = 1'b0; pin_in = 8'hFF; reg_we = 1'b0; reg_addr = A_STATUS; reg_wdata = '0;
    cur = 8'hFF;
    #23;
    // R1 reset values
    rd(A_STATUS, v); check("R1 status", v, 32'h0);
    rd(A_ENABLE, v); check("R1 enable", v, 32'h0);
    rd(A_SENSE, v);  check("R1 sense", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mstat = 8'h00; menab = 8'h00; msense = 24'h0; mprev = 8'hFF;

    // R2 / R3 enable plain and masked
    step(cur, 1'b1, A_ENABLE, 32'h5A);
    rd(A_ENABLE, v); check("R2 enable readback", v, 32'h5A);
    step(cur, 1'b1, A_ENABLE | A_MASKED, 32'h0F03);
    rd(A_ENABLE, v); check("R3 masked enable", v, 32'h53);
    step(cur, 1'b1, A_STATUS | A_MASKED, 32'h0101);
    rd(A_STATUS, v); check("R3 masked status", v, 32'h01);
    check("R11 irq on enabled bit", {31'h0, irq}, 32'h1);
    step(cur, 1'b1, A_STATUS, 32'h00);
    rd(A_STATUS, v); check("R3 plain status", v, 32'h00);

    // R4 masked sense writes
    step(cur, 1'b1, A_SENSE | A_MASKED, 32'h01_000101);
    rd(A_SENSE, v); check("R4 pin0 rising", v, 32'h000101);
    step(cur, 1'b1, A_SENSE | A_MASKED, 32'h02_FFFFFF);
    rd(A_SENSE, v); check("R4 pin1 any edge", v, 32'h020303);
    rd(A_ACK, v); check("R2 ack reads zero", v, 32'h0);
    rd(A_STATUS | A_MASKED, v); check("R2 alias reads zero", v, 32'h0);

    // R6 rising only
    cur = 8'hFE; idle();
    rd(A_STATUS, v); check("R6 fall ignored", v, 32'h00);
    cur = 8'hFF; idle();
    rd(A_STATUS, v); check("R6 rise sets", v, 32'h01);

    // R9 write-one-to-clear
    step(cur, 1'b1, A_ACK, 32'hFE);
    rd(A_STATUS, v); check("R9 zeros ignored", v, 32'h01);
    step(cur, 1'b1, A_ACK, 32'h01);
    rd(A_STATUS, v); check("R9 one clears", v, 32'h00);

    // R10 edge wins over simultaneous clear
    cur = 8'hFE; idle();
    cur = 8'hFF; step(cur, 1'b1, A_ACK, 32'h01);
    rd(A_STATUS, v); check("R10 edge beats clear", v, 32'h01);
    step(cur, 1'b1, A_ACK, 32'h01);

    // R8 any edge
    cur = 8'hFD; idle();
    rd(A_STATUS, v); check("R8 falling", v, 32'h02);
    step(cur, 1'b1, A_ACK, 32'h02);
    cur = 8'hFF; idle();
    rd(A_STATUS, v); check("R8 rising", v, 32'h02);
    step(cur, 1'b1, A_ACK, 32'h02);

    // R7 falling only, R12 sticky
    step(cur, 1'b1, A_SENSE, 32'h020703);
    rd(A_STATUS, v); check("R7 no event", v, 32'h00);
    cur = 8'hFB; idle();
    rd(A_STATUS, v); check("R7 fall sets", v, 32'h04);
    cur = 8'hFF; idle();
    rd(A_STATUS, v); check("R12 sticky after release", v, 32'h04);
    step(cur, 1'b1, A_ACK, 32'h04);
    rd(A_STATUS, v); check("R7 rise ignored", v, 32'h00);

    // R5 level modes
    step(cur, 1'b1, A_SENSE, 32'h02070B);
    idle();
    rd(A_STATUS, v); check("R5 level high sets", v, 32'h08);
    step(cur, 1'b1, A_ACK, 32'h08);
    rd(A_STATUS, v); check("R5 clear blocked by level", v, 32'h08);
    cur = 8'hF7; idle();
    step(cur, 1'b1, A_ACK, 32'h08);
    rd(A_STATUS, v); check("R5 clear after level gone", v, 32'h00);
    cur = 8'hE7; idle();
    rd(A_STATUS, v); check("R5 level low sets", v, 32'h10);

    // R11 gating
    check("R11 irq with bit4 enabled", {31'h0, irq}, 32'h1);
    step(cur, 1'b1, A_ENABLE, 32'h00);
    check("R11 irq masked", {31'h0, irq}, 32'h0);
    step(cur, 1'b1, A_ENABLE, 32'h10);
    check("R11 irq re-enabled", {31'h0, irq}, 32'h1);

    cur = 8'hFF; idle();
    step(cur, 1'b1, A_ACK, 32'hFF);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic        we;
      if ($urandom % 4 == 0) cur = cur ^ 8'($urandom);
      we = ($urandom % 3 == 0);
      case ($urandom % 7)
        0: a = A_STATUS;
        1: a = A_STATUS | A_MASKED;
        2: a = A_ENABLE;
        3: a = A_ENABLE | A_MASKED;
        4: a = A_SENSE;
        5: a = A_SENSE | A_MASKED;
        default: a = A_ACK;
      endcase
      step(cur, we, a, $urandom);
      rd(A_ENABLE, v); check("R3 random enable", v, {24'h0, menab});
      rd(A_SENSE, v);  check("R4 random sense", v, {8'h0, msense});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule